// File: doc/BRIEF.md
# Paged Register Address Decoder

This block sits between an already decoded serial command and a register file whose internal address space is wider than the command's address field. Each command carries a 5-bit register address with a read or write strobe. The block joins that address with a 7-bit page value, which is held in a write-only page register, to form a 12-bit internal address. It also drives a one-hot register select and the read and write enables towards the register file.

The page register sits at command address 31 on every page. Software can therefore always move to another page, even while an unpopulated page is selected. Two parameter bit masks mark which pages exist and which register slots exist within a page. An access that lands outside them has no effect, returns zero, and raises an error pulse.

Top module: `page_addr_map`

## Requirements
- R1: `rf_addr` always equals `{page, cmd_addr}`, where page is the current 7-bit page register value.
- R2: After reset the page register holds 0, so the first access to address `a` maps to internal address `a`.
- R3: A write to address 31 loads the page register from `cmd_wdata[6:0]`, and the other data bits are ignored. The new page applies from the next command onward. The write works from any page, including an unpopulated one, and no other command alters the page.
- R4: A write to address 31 drives no bit of `rf_sel`, does not assert `rf_wr_en` and raises no error.
- R5: A read of address 31 returns zero on `cmd_rdata`, does not assert `rf_rd_en` and raises no error.
- R6: A valid access drives `rf_sel` one-hot with bit `cmd_addr` set. A valid read asserts `rf_rd_en` and returns `rf_rdata` on `cmd_rdata` in the same cycle. A valid write asserts `rf_wr_en`. A valid access is a command to an address other than 31, where bit `page` of `USED_PAGES` and bit `cmd_addr` of `USED_REGS` are both 1.
- R7: An access to an unpopulated page or register slot, other than address 31, drives `rf_sel` to zero and asserts neither enable, so writes are discarded. A read of such a slot returns zero.
- R8: `acc_err` is high in the cycle after an R7 access and low after every other cycle. Back-to-back bad accesses keep it high for one cycle each.
- R9: Without `cmd_valid`, `rf_sel`, both enables and `cmd_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 5 | Command register address |
| cmd_wdata | input | DATA_W | Write data; bits [6:0] feed the page register |
| rf_rdata | input | DATA_W | Read data from the register file |
| rf_addr | output | 12 | Internal address {page, cmd_addr} |
| rf_sel | output | 32 | One-hot register select |
| rf_rd_en | output | 1 | Register file read enable |
| rf_wr_en | output | 1 | Register file write enable |
| cmd_rdata | output | DATA_W | Read data returned to the command side |
| acc_err | output | 1 | One-cycle pulse after an access to an unpopulated slot |

## Verification
The address, select, enable and read data outputs are combinational, so they are due in the same cycle as the command. The page register changes at the edge that ends a page write, so it is visible from the next command. `acc_err` is registered and is due one cycle after its command. The bench drives every command just after a falling edge and pushes one expected item per cycle. The monitor checks the combinational fields two nanoseconds later, and checks the error flag for each item one cycle after its command.

// File: rtl/page_addr_map.sv
module page_addr_map #(
  parameter int PAGE_W = 7,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 24,
  parameter logic [2**PAGE_W-1:0] USED_PAGES = 128'h0000_0000_0000_0000_0000_0000_0003_000F,
  parameter logic [2**ADDR_W-1:0] USED_REGS  = 32'h3FFF_FFFF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic                      cmd_write,
  input  logic [ADDR_W-1:0]         cmd_addr,
  input  logic [DATA_W-1:0]         cmd_wdata,
  input  logic [DATA_W-1:0]         rf_rdata,
  output logic [PAGE_W+ADDR_W-1:0]  rf_addr,
  output logic [2**ADDR_W-1:0]      rf_sel,
  output logic                      rf_rd_en,
  output logic                      rf_wr_en,
  output logic [DATA_W-1:0]         cmd_rdata,
  output logic                      acc_err
);

  localparam int NREG = 2**ADDR_W;
  localparam logic [ADDR_W-1:0] PAGE_SLOT = ADDR_W'(NREG - 1);

  logic [PAGE_W-1:0] page_q;

  wire to_page = cmd_addr == PAGE_SLOT;
  wire slot_ok = USED_PAGES[page_q] && USED_REGS[cmd_addr];
  wire live    = cmd_valid && !to_page && slot_ok;
  wire bad     = cmd_valid && !to_page && !slot_ok;
  wire pg_wr   = cmd_valid && cmd_write && to_page;

  assign rf_addr   = {page_q, cmd_addr};
  assign rf_sel    = live ? (NREG'(1) << cmd_addr) : '0;
  assign rf_rd_en  = live && !cmd_write;
  assign rf_wr_en  = live && cmd_write;
  assign cmd_rdata = rf_rd_en ? rf_rdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q  <= '0;
      acc_err <= 1'b0;
    end else begin
      if (pg_wr) page_q <= cmd_wdata[PAGE_W-1:0];
      acc_err <= bad;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rf_sel)); // R6

  AST_PAGE_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pg_wr |-> (rf_sel == '0 && !rf_wr_en)); // R4

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_wr |=> $stable(page_q)); // R3

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !acc_err); // R8

  AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !slot_ok) |-> (cmd_rdata == '0 && !rf_rd_en && !rf_wr_en)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (rf_sel == '0 && !rf_rd_en && !rf_wr_en && cmd_rdata == '0)); // R9

endmodule

// File: tb/page_addr_map_tb_top.sv
module page_addr_map_tb_top;
  localparam int DW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [4:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0, rf_rdata = '0;
  logic [11:0] rf_addr;
  logic [31:0] rf_sel;
  logic rf_rd_en, rf_wr_en, acc_err;
  logic [DW-1:0] cmd_rdata;

  always #4 clk = ~clk;

  page_addr_map dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rf_rdata(rf_rdata),
    .rf_addr(rf_addr), .rf_sel(rf_sel), .rf_rd_en(rf_rd_en), .rf_wr_en(rf_wr_en),
    .cmd_rdata(cmd_rdata), .acc_err(acc_err)
  );

  typedef struct packed {
    logic [11:0]   addr;
    logic [31:0]   sel;
    logic          rd;
    logic          wr;
    logic [DW-1:0] rdata;
    logic          err;
    logic [7:0]    req;
  } exp_t;

  exp_t q[$];
  int vectors = 0, fails = 0;
  logic [6:0] model_page = '0;
  logic [127:0] used_pages = 128'h0000_0000_0000_0000_0000_0000_0003_000F;
  logic [31:0] used_regs = 32'h3FFF_FFFF;
  bit done = 0;

  task automatic chk(input string what, input int req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cmd(input logic v, input logic w, input logic [4:0] a,
                     input logic [DW-1:0] d, input logic [DW-1:0] rd, input int req);
    exp_t e;
    logic ok;
    @(negedge clk);
    cmd_valid = v; cmd_write = w; cmd_addr = a; cmd_wdata = d; rf_rdata = rd;
    ok = used_pages[model_page] && used_regs[a];
    e.addr  = {model_page, a};
    e.sel   = (v && a != 5'd31 && ok) ? (32'd1 << a) : 32'd0;
    e.rd    = v && a != 5'd31 && ok && !w;
    e.wr    = v && a != 5'd31 && ok && w;
    e.rdata = e.rd ? rd : '0;
    e.err   = v && a != 5'd31 && !ok;
    e.req   = 8'(req);
    q.push_back(e);
    if (v && w && a == 5'd31) model_page = d[6:0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cmd(1'b0, 1'b0, 5'd0, '0, 24'h123456, 9);
  endtask

  initial begin : monitor
    exp_t e;
    logic prev_err;
    int prev_req;
    prev_err = 1'b0;
    prev_req = 8;
    forever begin
      @(negedge clk);
      #2;
      if (done) break;
      if (rst_n) chk("acc_err", prev_req, 64'(acc_err), 64'(prev_err));
      if (q.size() != 0) begin
        e = q.pop_front();
        chk("rf_addr", 1, 64'(rf_addr), 64'(e.addr));
        chk("rf_sel", e.req, 64'(rf_sel), 64'(e.sel));
        chk("rf_rd_en", e.req, 64'(rf_rd_en), 64'(e.rd));
        chk("rf_wr_en", e.req, 64'(rf_wr_en), 64'(e.wr));
        chk("cmd_rdata", e.req, 64'(cmd_rdata), 64'(e.rdata));
        prev_err = e.err;
        prev_req = e.err ? 8 : int'(e.req);
      end else begin
        prev_err = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("reset acc_err", 2, 64'(acc_err), 64'd0);
    rst_n = 1'b1;
    idle(2);                                        // R9
    cmd(1, 0, 5'd3, '0, 24'hA1B2C3, 2);             // R2: page 0 after reset
    cmd(1, 1, 5'd5, 24'h00BEEF, '0, 6);             // R6 write
    cmd(1, 1, 5'd31, 24'hFFFF02, '0, 4);            // R3 R4: page 2, upper bits ignored
    cmd(1, 0, 5'd7, '0, 24'h0F0F0F, 3);             // R3: new page visible next command
    cmd(1, 0, 5'd31, '0, 24'hFFFFFF, 5);            // R5
    cmd(1, 1, 5'd31, 24'h000004, '0, 3);            // page 4 unpopulated
    cmd(1, 0, 5'd1, '0, 24'h777777, 7);             // R7 R8
    cmd(1, 1, 5'd2, 24'h000055, '0, 7);             // R7 R8 back-to-back
    idle(1);                                        // R8 error clears
    cmd(1, 1, 5'd31, 24'h000011, '0, 3);            // R3 from an unpopulated page -> 17
    cmd(1, 0, 5'd30, '0, 24'h333333, 7);            // R7 unpopulated register slot
    cmd(1, 0, 5'd29, '0, 24'h444444, 6);            // R6 page 17 addr 29
    cmd(1, 1, 5'd0, 24'h00AAAA, '0, 6);             // R6 write addr 0
    cmd(1, 1, 5'd31, 24'h00007F, '0, 4);            // page 127
    cmd(1, 1, 5'd31, 24'h000001, '0, 4);            // R3 from page 127 -> 1
    cmd(1, 0, 5'd31, '0, 24'h999999, 5);            // R5 on page 1
    cmd(1, 0, 5'd17, '0, 24'h5A5A5A, 1);            // R1 page 1
    idle(3);                                        // R9
    @(negedge clk);
    #3;
    done = 1;
    #1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule